// File: doc/BRIEF.md
# Timed Low-Power Halt Controller

This block parks the CPU in a halt-style low-power state and brings it back on a time-base edge. Software asks for the halt by writing the halt-start bit. The block then drops the CPU run enable and the peripheral enable, and waits for a falling edge on one of several time-base taps. A select input picks the tap. The tap is asynchronous, so it passes through a two-flop synchronizer and its falling edge is detected in the system clock domain.

On the wake edge the halt-start bit clears itself. The CPU then resumes in one of two ways. In a plain resume it continues after the halting write. In an interrupt resume the block issues a one-cycle time-base interrupt dispatch. The interrupt resume is chosen only when the interrupt master flag, the time-base interrupt enable and the time-base enable were all set at entry.

If flash auto power-down was off at entry, a settling wait runs before the CPU restarts. In this wait the peripherals run but the CPU stays held. The wait is 1024 fast-clock cycles after a halt taken from fast mode, or 8 slow-clock ticks after a halt taken from slow mode. A pending watchdog interrupt blocks entry, and the asynchronous reset ends a halt at any time.

Top module: `lp_halt_ctl`

## Requirements
- R1: On reset, asserted asynchronously and at any time including during a halt, the outputs take these values: `mode_o`=0 (RUN), `cpu_run_o`=1, `periph_en_o`=1, `halt_bit_o`=0, `tb_irq_o`=0, `tb_dispatch_o`=0 and `run_slow_o`=0 (fast mode).
- R2: A write with `wr_en_i`=1, `wr_halt_i`=1 in RUN with `wdt_pend_i`=0 gives, from the next cycle, `mode_o`=1 (HALT), `halt_bit_o`=1, `cpu_run_o`=0 and `periph_en_o`=0.
- R3: A halt-start write while `wdt_pend_i`=1 is ignored, and so is a write of 0 to the bit; `mode_o` stays 0.
- R4: HALT ends only on a falling edge of `tb_taps_i[tb_sel_i]`, detected after a two-flop synchronizer and one history flop. Edges on unselected taps have no effect. `halt_bit_o` clears when HALT is left.
- R5: If the AND of `imf_i`, `tb_ie_i` and `tb_en_i` was 0 at entry and `flash_apd_i` was 1, the wake edge returns the block straight to RUN with no dispatch.
- R6: If that AND was 1 at entry, exactly one cycle of `mode_o`=3 (IRQ_DISPATCH) with `tb_dispatch_o`=1 and `cpu_run_o`=1 comes before RUN.
- R7: `tb_en_i`=1 at entry sets `tb_irq_o`; the flag clears when IRQ_DISPATCH is left.
- R8: If `flash_apd_i` was 0 at entry from fast mode, the wake edge leads to `mode_o`=2 (WAIT) for exactly 1024 cycles, with `periph_en_o`=1 and `cpu_run_o`=0.
- R9: If `flash_apd_i` was 0 at entry from slow mode (`slow_mode_i`=1), WAIT lasts until 8 cycles with `slow_tick_i`=1 have been counted.
- R10: In WAIT, a falling edge on the selected tap with `tb_em_i`=1 sets `tb_irq_o`. A dispatch still waits for the end of WAIT.
- R11: `run_slow_o` follows `slow_mode_i` in RUN and holds the entry value in every other mode, so the block returns to the pre-halt run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| wr_en_i | input | 1 | control register write strobe |
| wr_halt_i | input | 1 | halt-start bit value being written |
| tb_sel_i | input | SEL_W | time-base tap select |
| tb_taps_i | input | NTAPS | asynchronous time-base taps |
| tb_en_i | input | 1 | time-base enable |
| tb_ie_i | input | 1 | time-base interrupt enable |
| imf_i | input | 1 | interrupt master flag |
| flash_apd_i | input | 1 | flash auto power-down enable |
| slow_mode_i | input | 1 | current run mode is slow clock |
| slow_tick_i | input | 1 | one pulse per slow-clock cycle |
| wdt_pend_i | input | 1 | watchdog interrupt pending |
| cpu_run_o | output | 1 | CPU clock enable |
| periph_en_o | output | 1 | peripheral enable |
| halt_bit_o | output | 1 | halt-start bit readback |
| tb_irq_o | output | 1 | time-base interrupt latch |
| tb_dispatch_o | output | 1 | start time-base interrupt service |
| run_slow_o | output | 1 | run mode to resume in |
| mode_o | output | 2 | 0 RUN, 1 HALT, 2 WAIT, 3 IRQ_DISPATCH |

## Verification
A corrupted mode register shows on `cpu_run_o` and `periph_en_o` in the same cycle, because both decode it directly. A stale capture of the resume kind only shows at the wake edge, as a missing or extra dispatch cycle. A counter that loads the wrong value stays hidden until WAIT ends. It then shows as a WAIT of the wrong length, up to 1024 cycles later. The bench therefore compares every output on every clock against a behavioural model and also measures WAIT lengths and dispatch counts directly.

// File: rtl/lp_halt_pkg.sv
package lp_halt_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_WAIT = 2'd2,
    MODE_IRQ  = 2'd3
  } halt_mode_e;
endpackage

// File: rtl/tb_edge_sync.sv
module tb_edge_sync #(
  parameter int NTAPS       = 4,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTAPS-1:0] taps_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fall_o
);
  logic              tap_sel;
  logic [SYNC_STAGES:0] pipe_q;

  assign tap_sel = taps_i[sel_i];

  // synchronizer stages plus one history flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], tap_sel};
  end

  assign fall_o = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/halt_wait_cnt.sv
module halt_wait_cnt #(
  parameter int FAST_LOG2 = 10,
  parameter int SLOW_LOG2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic load_slow_i,
  input  logic active_i,
  input  logic tick_slow_i,
  input  logic slow_tick_i,
  output logic done_o
);
  localparam int MAXL = (FAST_LOG2 > SLOW_LOG2) ? FAST_LOG2 : SLOW_LOG2;
  localparam int CW   = MAXL + 1;
  localparam logic [CW-1:0] ONE       = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] FAST_LOAD = ONE << FAST_LOG2;
  localparam logic [CW-1:0] SLOW_LOAD = ONE << SLOW_LOG2;

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = tick_slow_i ? slow_tick_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (load_i)                          cnt_q <= load_slow_i ? SLOW_LOAD : FAST_LOAD;
    else if (active_i && tick && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign done_o = active_i & tick & (cnt_q == ONE);
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
  import lp_halt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_halt_i,
  input  logic       tb_en_i,
  input  logic       tb_ie_i,
  input  logic       imf_i,
  input  logic       flash_apd_i,
  input  logic       slow_mode_i,
  input  logic       wdt_pend_i,
  input  logic       fall_i,
  input  logic       wait_done_i,
  output logic       load_o,
  output logic       wait_active_o,
  output logic       run_slow_o,
  output logic       tb_irq_o,
  output halt_mode_e mode_o
);
  halt_mode_e state_q;
  logic need_wait_q, irq_mode_q, latch_q, run_slow_q;
  logic req;

  assign req = wr_en_i & wr_halt_i & ~wdt_pend_i & (state_q == MODE_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= MODE_RUN;
      need_wait_q <= 1'b0;
      irq_mode_q  <= 1'b0;
      latch_q     <= 1'b0;
      run_slow_q  <= 1'b0;
    end else begin
      unique case (state_q)
        MODE_RUN: begin
          run_slow_q <= slow_mode_i;
          if (req) begin
            state_q     <= MODE_HALT;
            need_wait_q <= ~flash_apd_i;
            irq_mode_q  <= imf_i & tb_ie_i & tb_en_i;
            if (tb_en_i) latch_q <= 1'b1;
          end
        end
        MODE_HALT: begin
          if (fall_i) begin
            if (need_wait_q)     state_q <= MODE_WAIT;
            else if (irq_mode_q) state_q <= MODE_IRQ;
            else                 state_q <= MODE_RUN;
          end
        end
        MODE_WAIT: begin
          if (fall_i && tb_en_i) latch_q <= 1'b1;
          if (wait_done_i) state_q <= irq_mode_q ? MODE_IRQ : MODE_RUN;
        end
        MODE_IRQ: begin
          latch_q <= 1'b0;
          state_q <= MODE_RUN;
        end
        default: state_q <= MODE_RUN;
      endcase
    end
  end

  assign load_o        = req;
  assign wait_active_o = (state_q == MODE_WAIT);
  assign run_slow_o    = run_slow_q;
  assign tb_irq_o      = latch_q;
  assign mode_o        = state_q;
endmodule

// File: rtl/lp_halt_ctl.sv
module lp_halt_ctl
  import lp_halt_pkg::*;
#(
  parameter int NTAPS     = 4,
  parameter int SEL_W     = $clog2(NTAPS),
  parameter int FAST_LOG2 = 10,
  parameter int SLOW_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_halt_i,
  input  logic [SEL_W-1:0] tb_sel_i,
  input  logic [NTAPS-1:0] tb_taps_i,
  input  logic             tb_en_i,
  input  logic             tb_ie_i,
  input  logic             imf_i,
  input  logic             flash_apd_i,
  input  logic             slow_mode_i,
  input  logic             slow_tick_i,
  input  logic             wdt_pend_i,
  output logic             cpu_run_o,
  output logic             periph_en_o,
  output logic             halt_bit_o,
  output logic             tb_irq_o,
  output logic             tb_dispatch_o,
  output logic             run_slow_o,
  output logic [1:0]       mode_o
);
  logic       fall, wait_done, load, wait_active, run_slow;
  halt_mode_e mode;

  tb_edge_sync #(.NTAPS(NTAPS), .SEL_W(SEL_W), .SYNC_STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .taps_i (tb_taps_i),
    .sel_i  (tb_sel_i),
    .fall_o (fall)
  );

  halt_wait_cnt #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_slow_i (slow_mode_i),
    .active_i    (wait_active),
    .tick_slow_i (run_slow),
    .slow_tick_i (slow_tick_i),
    .done_o      (wait_done)
  );

  halt_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_halt_i     (wr_halt_i),
    .tb_en_i       (tb_en_i),
    .tb_ie_i       (tb_ie_i),
    .imf_i         (imf_i),
    .flash_apd_i   (flash_apd_i),
    .slow_mode_i   (slow_mode_i),
    .wdt_pend_i    (wdt_pend_i),
    .fall_i        (fall),
    .wait_done_i   (wait_done),
    .load_o        (load),
    .wait_active_o (wait_active),
    .run_slow_o    (run_slow),
    .tb_irq_o      (tb_irq_o),
    .mode_o        (mode)
  );

  assign mode_o        = mode;
  assign cpu_run_o     = (mode == MODE_RUN) || (mode == MODE_IRQ);
  assign periph_en_o   = (mode != MODE_HALT);
  assign halt_bit_o    = (mode == MODE_HALT);
  assign tb_dispatch_o = (mode == MODE_IRQ);
  assign run_slow_o    = run_slow;
endmodule

// File: rtl/lp_halt_ctl_chk.sv
module lp_halt_ctl_chk
  import lp_halt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wr_halt_i,
  input logic       wdt_pend_i,
  input logic       cpu_run_o,
  input logic       periph_en_o,
  input logic       tb_irq_o,
  input logic       tb_dispatch_o,
  input logic       run_slow_o,
  input logic [1:0] mode_o
);
  assert_halt_gates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_HALT) |-> (!cpu_run_o && !periph_en_o));

  assert_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RUN && wr_en_i && wr_halt_i && !wdt_pend_i) |=> (mode_o == MODE_HALT));

  assert_wdt_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RUN && wdt_pend_i) |=> (mode_o == MODE_RUN));

  assert_dispatch_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_IRQ) |=> (mode_o == MODE_RUN && !tb_dispatch_o));

  assert_latch_at_dispatch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_IRQ) |-> tb_irq_o);

  assert_wait_gates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_WAIT) |-> (!cpu_run_o && periph_en_o));

  assert_mode_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_RUN) |=> $stable(run_slow_o));
endmodule

bind lp_halt_ctl lp_halt_ctl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_halt_i     (wr_halt_i),
  .wdt_pend_i    (wdt_pend_i),
  .cpu_run_o     (cpu_run_o),
  .periph_en_o   (periph_en_o),
  .tb_irq_o      (tb_irq_o),
  .tb_dispatch_o (tb_dispatch_o),
  .run_slow_o    (run_slow_o),
  .mode_o        (mode_o)
);

// File: tb/tb_lp_halt_ctl.sv
`timescale 1ns/1ps
module tb_lp_halt_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, wr_halt = 0, tb_en = 0, tb_ie = 0, imf = 0;
  logic       apd = 1, slow_mode = 0, slow_tick = 0, wdt = 0;
  logic [1:0] sel = 2'd1;
  logic [3:0] taps = 4'd0;
  logic       cpu_run, periph_en, halt_bit, tb_irq, tb_disp, run_slow;
  logic [1:0] mode;

  int    total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    tick_gen = 0;
  bit    done = 0;

  always #4 clk = ~clk;

  lp_halt_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_halt_i(wr_halt),
    .tb_sel_i(sel), .tb_taps_i(taps), .tb_en_i(tb_en), .tb_ie_i(tb_ie),
    .imf_i(imf), .flash_apd_i(apd), .slow_mode_i(slow_mode),
    .slow_tick_i(slow_tick), .wdt_pend_i(wdt), .cpu_run_o(cpu_run),
    .periph_en_o(periph_en), .halt_bit_o(halt_bit), .tb_irq_o(tb_irq),
    .tb_dispatch_o(tb_disp), .run_slow_o(run_slow), .mode_o(mode)
  );

  // behavioural reference
  int m_mode, m_cnt, s1, s2, s3;
  bit m_need, m_irq, m_latch, m_slow;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_latch = 0; m_slow = 0; m_need = 0; m_irq = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit fall, tick;
      fall = (s3 == 1) && (s2 == 0);
      tick = m_slow ? slow_tick : 1'b1;
      s3 = s2; s2 = s1; s1 = int'(taps[sel]);
      case (m_mode)
        0: begin
          if (wr_en && wr_halt && !wdt) begin
            m_mode = 1; m_need = !apd; m_irq = imf && tb_ie && tb_en;
            if (tb_en) m_latch = 1;
            m_cnt = slow_mode ? 8 : 1024;
          end
          m_slow = slow_mode;
        end
        1: if (fall) m_mode = m_need ? 2 : (m_irq ? 3 : 0);
        2: begin
          if (fall && tb_en) m_latch = 1;
          if (tick) begin
            if (m_cnt == 1) m_mode = m_irq ? 3 : 0;
            else m_cnt--;
          end
        end
        default: begin m_latch = 0; m_mode = 0; end
      endcase
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("mode", mode, m_mode);
      chk("cpu_run", cpu_run, (m_mode == 0 || m_mode == 3));
      chk("periph_en", periph_en, (m_mode != 1));
      chk("halt_bit", halt_bit, (m_mode == 1));
      chk("tb_irq", tb_irq, m_latch);
      chk("dispatch", tb_disp, (m_mode == 3));
      chk("run_slow", run_slow, m_slow);
    end
  end

  // slow-clock tick generator
  always @(negedge clk) begin
    slow_tick <= tick_gen && (cyc % 4 == 0);
    cyc <= cyc + 1;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_halt(bit v);
    @(negedge clk); wr_en = 1; wr_halt = v;
    @(negedge clk); wr_en = 0; wr_halt = 0;
  endtask

  task automatic pulse_tap(int i);
    @(negedge clk); taps[i] = 1'b1;
    cycles(4);
    taps[i] = 1'b0;
  endtask

  // wait until mode m appears, then count cycles spent in it
  task automatic count_mode(int m, output int n, output int ticks);
    int guard = 0;
    n = 0; ticks = 0;
    @(negedge clk); #2;
    while (mode != 2'(m) && guard < 4000) begin @(negedge clk); #2; guard++; end
    while (mode == 2'(m) && guard < 4000) begin
      n++; if (slow_tick) ticks++;
      @(negedge clk); #2; guard++;
    end
  endtask

  initial begin
    int n, t;
    cur_req = "R1";
    cycles(3);
    #2 chk("reset mode", mode, 0);
    chk("reset run_slow", run_slow, 0);
    @(negedge clk); rst_n = 1'b1;
    cycles(3);

    cur_req = "R3";
    wdt = 1; write_halt(1); cycles(3);
    #2 chk("wdt blocks entry", mode, 0);
    wdt = 0; write_halt(0); cycles(3);
    #2 chk("zero write ignored", mode, 0);

    cur_req = "R2"; apd = 1; sel = 2'd1;
    write_halt(1);
    #2 chk("halt entered", mode, 1);
    chk("cpu stopped", cpu_run, 0);
    cur_req = "R4";
    pulse_tap(2); cycles(6);
    #2 chk("unselected tap ignored", mode, 1);
    cur_req = "R5";
    pulse_tap(1); cycles(6);
    #2 chk("plain resume", mode, 0);
    chk("halt bit cleared R4", halt_bit, 0);

    cur_req = "R8"; apd = 0;
    write_halt(1); pulse_tap(1);
    count_mode(2, n, t);
    chk("fast wait length", n, 1024);

    cur_req = "R11"; slow_mode = 1; tick_gen = 1; cycles(2);
    write_halt(1);
    slow_mode = 0; cycles(3);
    #2 chk("run mode held in halt", run_slow, 1);
    slow_mode = 1;
    cur_req = "R9";
    pulse_tap(1);
    count_mode(2, n, t);
    chk("slow wait ticks", t, 8);
    cur_req = "R11";
    chk("resumed in slow mode", run_slow, 1);
    tick_gen = 0; slow_mode = 0; cycles(3);

    cur_req = "R10"; apd = 0; tb_en = 0; imf = 1; tb_ie = 1;
    write_halt(1);
    tb_en = 1; pulse_tap(1); cycles(5);
    pulse_tap(1); cycles(5);
    #2 chk("in wait", mode, 2);
    chk("latch set in wait", tb_irq, 1);
    count_mode(2, n, t); cycles(1);
    tb_en = 0;

    cur_req = "R6"; tb_en = 1; apd = 1; sel = 2'd3;
    write_halt(1);
    cur_req = "R7";
    #2 chk("latch set at entry", tb_irq, 1);
    cur_req = "R6";
    pulse_tap(3);
    count_mode(3, n, t);
    chk("one dispatch cycle", n, 1);
    cur_req = "R7";
    chk("latch cleared", tb_irq, 0);

    cur_req = "R6"; apd = 0;
    write_halt(1); pulse_tap(3);
    count_mode(2, n, t);
    chk("wait before dispatch", n, 1024);
    #2 chk("dispatch after wait", mode, 3);
    cycles(3);

    cur_req = "R1"; tb_en = 0; apd = 1; slow_mode = 1; cycles(2);
    write_halt(1); cycles(2);
    #1 rst_n = 1'b0;
    #1 chk("async exit", mode, 0);
    chk("fast after reset", run_slow, 0);
    cycles(2); rst_n = 1'b1; cycles(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule